// File: doc/BRIEF.md
# Fixed-Port DMA Transfer Channel

This block is a single DMA channel that moves data between a memory region and one fixed peripheral port. Each accepted request moves one unit, either a byte or a 16-bit word, using two bus cycles: a read that loads an internal holding register, then a write. The memory side uses a 24-bit address that steps after every unit. The port side uses an 8-bit register whose value is padded with ones to a full 24-bit address, and that address never moves.

Software sets up the channel through a small register write port. It loads the memory address, the port byte and the unit count, then sets the enable bit in the control word. Each of several request lines can then start a transfer. The request line that starts a transfer also sets its direction. One designated line, a serial receiver's data-ready event, moves data from the port into memory. Every other line moves data from memory out to the port. When the count runs out, the channel turns itself off and raises a sticky done flag. If the interrupt enable is set, it also raises an interrupt.

Top module: `fpdma_channel`

## Requirements
- R1: After reset, `active`, `done` and `irq` are 0 and neither `bus_rd` nor `bus_wr` is asserted.
- R2: A write with `cfg_we` high loads the field selected by `cfg_sel`. Code 0 loads the memory address from bits 23:0. Code 1 loads the port byte from bits 7:0. Code 2 loads the count from bits 15:0. Code 3 loads the control word: bit 0 enable, bit 1 word size, bit 2 step down, bit 3 interrupt enable. A control write with bit 0 set clears `done`. Any write is ignored while a transfer is in progress.
- R3: Each served request produces exactly one read cycle and then one write cycle. `bus_word` follows the size bit. The write data equals the data read, and in byte mode bits 15:8 of the write data are 0.
- R4: When request line 0 starts a transfer, the read goes to the port address and the write goes to the memory address. Every other line reads the memory address and writes the port address.
- R5: The port address is 0xFFFF00 plus the port byte. It is the same for every cycle of every transfer.
- R6: After each unit the memory address moves by 1 in byte mode or by 2 in word mode. It moves down when the step-down bit is set and up otherwise. It wraps modulo 2^24.
- R7: The count decreases by one per unit. On the unit that brings it to zero, `active` falls and `done` rises and stays high. `irq` equals `done` AND the interrupt enable.
- R8: Starting with a count of 0 gives 65536 units. The count wraps to 0xFFFF and the channel stays active.
- R9: A request that arrives while the channel is disabled is dropped. It does not cause a transfer when the channel is enabled later.
- R10: A request that arrives during a transfer is held and served afterwards. Among pending requests, the lowest-numbered line is served first.
- R11: `bus_rd` and `bus_wr` are never high together. The strobe and `bus_addr` hold steady until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select code |
| cfg_wdata | input | 24 | Register write data |
| req | input | 4 | Transfer request lines, one-cycle pulses; line 0 is the receive-ready event |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken when bus_ready is high |
| bus_ready | input | 1 | Completes the current bus cycle |
| active | output | 1 | Channel enable state |
| done | output | 1 | Sticky end-of-count flag |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest cases to reach from the ports involve a register write or a new request that lands while a transfer is waiting on the bus. The stimulus produces them by making the bus model hold `bus_ready` low for several cycles. It waits until it sees a read strobe, then writes a new memory address and pulses another request line inside that window. Address wrap in both directions is reached by starting at 0xFFFFFF and at 0x000001. The zero-count start is shown by running several units from a count of 0 and checking that the channel stays active.

// File: rtl/fpdma_pkg.sv
package fpdma_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WRITE = 2'd2
   } seq_state_e;

   localparam logic [1:0] SEL_MEM   = 2'd0;
   localparam logic [1:0] SEL_PORT  = 2'd1;
   localparam logic [1:0] SEL_COUNT = 2'd2;
   localparam logic [1:0] SEL_CTRL  = 2'd3;

   localparam int CTL_EN   = 0;
   localparam int CTL_WORD = 1;
   localparam int CTL_DEC  = 2;
   localparam int CTL_IRQ  = 3;
endpackage

// File: rtl/fpdma_regs.sv
module fpdma_regs
   import fpdma_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int PORT_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              busy,
   input  logic              xfer_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PORT_W-1:0] port_lo,
   output logic [CNT_W-1:0]  cnt,
   output logic              en,
   output logic              word_mode,
   output logic              dec_mode,
   output logic              irq_en,
   output logic              done
);
   localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
   localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

   if (CNT_W > ADDR_W) begin : g_chk_cnt
      $error("count width must fit in the write data width");
   end
   if (PORT_W >= ADDR_W) begin : g_chk_port
      $error("port field must be narrower than the address");
   end

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] next_addr;
   logic              last_unit;
   logic              wr_ok;

   assign step      = word_mode ? STEP_WORD : STEP_BYTE;
   assign next_addr = dec_mode ? (mem_addr - step) : (mem_addr + step);
   assign last_unit = (cnt == CNT_ONE);
   assign wr_ok     = cfg_we & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         port_lo   <= '0;
         cnt       <= '0;
         en        <= 1'b0;
         word_mode <= 1'b0;
         dec_mode  <= 1'b0;
         irq_en    <= 1'b0;
         done      <= 1'b0;
      end else if (xfer_done) begin
         mem_addr <= next_addr;
         cnt      <= cnt - CNT_ONE;
         if (last_unit) begin
            en   <= 1'b0;
            done <= 1'b1;
         end
      end else if (wr_ok) begin
         case (cfg_sel)
            SEL_MEM:   mem_addr <= cfg_wdata;
            SEL_PORT:  port_lo  <= cfg_wdata[PORT_W-1:0];
            SEL_COUNT: cnt      <= cfg_wdata[CNT_W-1:0];
            default: begin
               en        <= cfg_wdata[CTL_EN];
               word_mode <= cfg_wdata[CTL_WORD];
               dec_mode  <= cfg_wdata[CTL_DEC];
               irq_en    <= cfg_wdata[CTL_IRQ];
               if (cfg_wdata[CTL_EN]) done <= 1'b0;
            end
         endcase
      end
   end

   AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> cnt == CNT_W'($past(cnt) - CNT_ONE)); // R7
   AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !en); // R7
   AST_BYTE_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done && !word_mode && !dec_mode |=> mem_addr == ADDR_W'($past(mem_addr) + STEP_BYTE)); // R6
   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && busy && !xfer_done |=> $stable(cnt) && $stable(port_lo)); // R2
endmodule

// File: rtl/fpdma_req.sv
module fpdma_req #(
   parameter int NUM_SRC = 4,
   parameter int RX_SRC  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic               en,
   input  logic               take,
   output logic               any_pend,
   output logic               sel_rx
);
   if (RX_SRC >= NUM_SRC) begin : g_chk_rx
      $error("receive source index out of range");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] below;
   logic [NUM_SRC-1:0] sel_oh;
   logic [NUM_SRC-1:0] clr;

   assign below[0]  = 1'b0;
   assign sel_oh[0] = pend[0];
   for (genvar i = 1; i < NUM_SRC; i++) begin : g_prio
      assign below[i]  = below[i-1] | pend[i-1];
      assign sel_oh[i] = pend[i] & ~below[i];
   end

   assign clr      = take ? sel_oh : '0;
   assign any_pend = |pend;
   assign sel_rx   = sel_oh[RX_SRC];

   always_ff @(posedge clk) begin
      if (!rst_n)   pend <= '0;
      else if (!en) pend <= '0;
      else          pend <= (pend & ~clr) | req;
   end

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh)); // R10
   AST_HELD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      any_pend && en && !take |=> any_pend || !en); // R10
endmodule

// File: rtl/fpdma_seq.sv
module fpdma_seq
   import fpdma_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              any_pend,
   input  logic              sel_rx,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [ADDR_W-1:0] port_addr,
   input  logic              word_mode,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   output logic              take,
   output logic              busy,
   output logic              xfer_done,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata
);
   localparam int BYTE_W = 8;

   if (DATA_W != 2 * BYTE_W) begin : g_chk_data
      $error("data path must be two bytes wide");
   end

   seq_state_e        state;
   logic              dir_rx;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] capture;

   assign capture   = word_mode ? bus_rdata
                                : {{(DATA_W-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
   assign take      = (state == SEQ_IDLE) && en && any_pend;
   assign busy      = (state != SEQ_IDLE);
   assign bus_rd    = (state == SEQ_READ);
   assign bus_wr    = (state == SEQ_WRITE);
   assign xfer_done = bus_wr && bus_ready;
   assign bus_word  = word_mode;
   assign bus_wdata = data_q;

   always_comb begin
      if (bus_rd) bus_addr = dir_rx ? port_addr : mem_addr;
      else        bus_addr = dir_rx ? mem_addr : port_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         dir_rx <= 1'b0;
         data_q <= '0;
      end else begin
         case (state)
            SEQ_IDLE: if (take) begin
               state  <= SEQ_READ;
               dir_rx <= sel_rx;
            end
            SEQ_READ: if (bus_ready) begin
               data_q <= capture;
               state  <= SEQ_WRITE;
            end
            SEQ_WRITE: if (bus_ready) state <= SEQ_IDLE;
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr)); // R11
   AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr)); // R11
   AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_ready |=> bus_wr); // R3
   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd) |-> $past(en)); // R9
endmodule

// File: rtl/fpdma_channel.sv
module fpdma_channel
   import fpdma_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int PORT_W  = 8,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter int NUM_SRC = 4,
   parameter int RX_SRC  = 0,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [ADDR_W-1:0]  cfg_wdata,
   input  logic [NUM_SRC-1:0] req,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic               bus_rd,
   output logic               bus_wr,
   output logic               bus_word,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata,
   input  logic               bus_ready,
   output logic               active,
   output logic               done,
   output logic               irq
);
   localparam int PAD_W = ADDR_W - PORT_W;

   logic [ADDR_W-1:0] mem_addr;
   logic [PORT_W-1:0] port_lo;
   logic [ADDR_W-1:0] port_addr;
   logic [CNT_W-1:0]  cnt;
   logic              en, word_mode, dec_mode, irq_en;
   logic              busy, xfer_done, take, any_pend, sel_rx;

   assign port_addr = {{PAD_W{1'b1}}, port_lo};
   assign active    = en;

   fpdma_regs #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .busy(busy), .xfer_done(xfer_done),
      .mem_addr(mem_addr), .port_lo(port_lo), .cnt(cnt), .en(en),
      .word_mode(word_mode), .dec_mode(dec_mode), .irq_en(irq_en), .done(done)
   );

   fpdma_req #(.NUM_SRC(NUM_SRC), .RX_SRC(RX_SRC)) u_req (
      .clk(clk), .rst_n(rst_n), .req(req), .en(en), .take(take),
      .any_pend(any_pend), .sel_rx(sel_rx)
   );

   fpdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .any_pend(any_pend), .sel_rx(sel_rx),
      .mem_addr(mem_addr), .port_addr(port_addr), .word_mode(word_mode),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .take(take), .busy(busy),
      .xfer_done(xfer_done), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
   );

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= done & irq_en;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = done & irq_en;
   end

   AST_PORT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(port_addr)); // R5
   AST_PORT_SIDE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (bus_addr == port_addr) || (bus_addr == mem_addr)); // R4
endmodule

// File: tb/fpdma_channel_test.sv
module fpdma_channel_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [23:0] cfg_wdata = '0;
   logic [3:0]  req = '0;
   logic [23:0] bus_addr;
   logic        bus_rd, bus_wr, bus_word;
   logic [15:0] bus_wdata, bus_rdata;
   logic        bus_ready = 1'b0;
   logic        active, done, irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] rd_val(input logic [23:0] a);
      return a[15:0] ^ 16'h5AC3;
   endfunction
   assign bus_rdata = rd_val(bus_addr);

   fpdma_channel uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req(req), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .active(active),
      .done(done), .irq(irq)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // reference model
   logic [23:0] m_addr = '0;
   logic [7:0]  m_port = '0;
   logic [15:0] m_cnt = '0;
   logic        m_en = 0, m_word = 0, m_dec = 0, m_ie = 0, m_done = 0;
   int          srcq[$];
   int          waits = 0;
   int          wcnt = 0;
   int          xfer_cnt = 0;
   int          served_sig = 0;
   logic [15:0] exp_data = '0;
   logic [23:0] last_rd = '0, last_wr = '0, prev_addr = '0;
   logic        prev_wait = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         chk(1'b0, "watchdog", cycles, WATCHDOG);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
      if (!rst_n) begin
         bus_ready = 1'b0;
      end else begin
         chk(active == m_en, "R7 active", active, m_en);
         chk(done == m_done, "R7 done", done, m_done);
         chk(irq == (m_done & m_ie), "R7 irq", irq, m_done & m_ie);
         if (bus_rd && bus_wr) chk(1'b0, "R11 overlap", 1, 0);
         if (prev_wait) chk(bus_addr == prev_addr && (bus_rd || bus_wr), "R11 hold", bus_addr, prev_addr);
         prev_wait = 1'b0;
         if (bus_rd || bus_wr) begin
            if (srcq.size() == 0) begin
               chk(1'b0, "R9 unexpected bus cycle", bus_addr, 0);
               bus_ready = 1'b1;
            end else begin
               logic        rx;
               logic [23:0] pa, ea;
               rx = (srcq[0] == 0);
               pa = {16'hFFFF, m_port};
               if (bus_rd) begin
                  ea = rx ? pa : m_addr;
                  chk(bus_addr == ea, "R4 read address", bus_addr, ea);
               end else begin
                  ea = rx ? m_addr : pa;
                  chk(bus_addr == ea, "R5 write address", bus_addr, ea);
               end
               chk(bus_word == m_word, "R3 size", bus_word, m_word);
               if (wcnt >= waits) begin
                  bus_ready = 1'b1;
                  wcnt = 0;
                  if (bus_rd) begin
                     exp_data = m_word ? rd_val(bus_addr) : {8'h00, rd_val(bus_addr)[7:0]};
                     last_rd  = bus_addr;
                  end else begin
                     chk(bus_wdata == exp_data, "R3 write data", bus_wdata, exp_data);
                     last_wr = bus_addr;
                     xfer_cnt++;
                     served_sig = served_sig * 16 + srcq[0];
                     void'(srcq.pop_front());
                     if (m_dec) m_addr = m_addr - (m_word ? 24'd2 : 24'd1);
                     else       m_addr = m_addr + (m_word ? 24'd2 : 24'd1);
                     m_cnt = m_cnt - 16'd1;
                     if (m_cnt == 16'd0) begin
                        m_en   = 1'b0;
                        m_done = 1'b1;
                        srcq.delete();
                     end
                  end
               end else begin
                  bus_ready = 1'b0;
                  wcnt++;
                  prev_wait = 1'b1;
                  prev_addr = bus_addr;
               end
            end
         end else begin
            bus_ready = 1'b0;
         end
      end
   end

   task automatic cfg(input logic [1:0] sel, input logic [23:0] d, input bit apply);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk);
      if (apply) begin
         case (sel)
            2'd0: m_addr = d;
            2'd1: m_port = d[7:0];
            2'd2: m_cnt  = d[15:0];
            default: begin
               m_en = d[0]; m_word = d[1]; m_dec = d[2]; m_ie = d[3];
               if (d[0]) m_done = 1'b0;
            end
         endcase
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic fire(input logic [3:0] mask);
      @(negedge clk);
      req = mask;
      @(posedge clk);
      if (m_en) for (int i = 0; i < 4; i++) if (mask[i]) srcq.push_back(i);
      @(negedge clk);
      req = '0;
   endtask

   task automatic drain();
      while (srcq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!active && !done && !irq, "R1 status", {active, done, irq}, 0);
      chk(!bus_rd && !bus_wr, "R1 bus idle", {bus_rd, bus_wr}, 0);

      // R2 R3 R5 R6 R7: byte, step up, transmit-side source, irq enabled
      waits = 0;
      cfg(2'd0, 24'h001000, 1);
      cfg(2'd1, 24'h000040, 1);
      cfg(2'd2, 24'd3, 1);
      cfg(2'd3, 24'h9, 1);
      for (int k = 0; k < 3; k++) begin fire(4'b0010); drain(); end
      chk(done && !active, "R7 end of count", {done, active}, 2);
      chk(irq == 1'b1, "R7 irq raised", irq, 1);
      chk(last_wr == 24'hFFFF40, "R5 port address", last_wr, 24'hFFFF40);

      // R4 R6: receive source, word, step down through zero, bus waits
      waits = 2;
      cfg(2'd0, 24'h000001, 1);
      cfg(2'd2, 24'd2, 1);
      cfg(2'd3, 24'h7, 1);
      for (int k = 0; k < 2; k++) begin fire(4'b0001); drain(); end
      chk(last_wr == 24'hFFFFFF, "R6 downward wrap", last_wr, 24'hFFFFFF);
      chk(last_rd == 24'hFFFF40, "R4 port read", last_rd, 24'hFFFF40);
      chk(done && !irq, "R7 irq masked", {done, irq}, 2);

      // R6: upward wrap from the top of the address space
      waits = 1;
      cfg(2'd0, 24'hFFFFFF, 1);
      cfg(2'd2, 24'd1, 1);
      cfg(2'd3, 24'h1, 1);
      fire(4'b0100); drain();
      cfg(2'd2, 24'd1, 1);
      cfg(2'd3, 24'h1, 1);
      fire(4'b1000); drain();
      chk(last_rd == 24'h000000, "R6 upward wrap", last_rd, 0);

      // R9: request while disabled is dropped
      cfg(2'd3, 24'h0, 1);
      n = xfer_cnt;
      fire(4'b0010);
      repeat (5) @(negedge clk);
      cfg(2'd2, 24'd1, 1);
      cfg(2'd3, 24'h1, 1);
      repeat (10) @(negedge clk);
      chk(xfer_cnt == n, "R9 dropped request", xfer_cnt, n);
      fire(4'b0010); drain();
      chk(xfer_cnt == n + 1, "R9 later request served", xfer_cnt, n + 1);

      // R10 R2: priority, held request, write ignored while busy
      waits = 3;
      served_sig = 0;
      cfg(2'd0, 24'h000200, 1);
      cfg(2'd2, 24'd4, 1);
      cfg(2'd3, 24'hB, 1);
      fire(4'b0110);
      while (!bus_rd) @(negedge clk);
      cfg(2'd0, 24'h123456, 0);
      fire(4'b1000);
      drain();
      fire(4'b0001);
      drain();
      chk(served_sig == 32'h1230, "R10 service order", served_sig, 32'h1230);
      chk(done == 1'b1, "R10 all served", done, 1);
      chk(last_wr == 24'h000206, "R2 busy write ignored", last_wr, 24'h000206);

      // R8: zero count runs on
      waits = 0;
      cfg(2'd2, 24'd0, 1);
      cfg(2'd3, 24'h1, 1);
      fire(4'b0100); drain();
      fire(4'b0100); drain();
      chk(active && !done, "R8 zero count continues", {active, done}, 2);
      cfg(2'd3, 24'h0, 1);
      @(negedge clk);
      chk(!active, "R2 disable by write", active, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule